// File: doc/BRIEF.md
# Data and Probe Symbol Framer

This block builds the symbol stream of a single-tone phase-shift-keyed modem. Each symbol is 3 bits wide and selects one of eight phase states. The line runs at a constant symbol rate. A strobe input marks each symbol period, and the block emits exactly one symbol for every strobe, so the output never stalls. The line rate in bits stays fixed no matter which user rate the upstream coder is running.

The stream is a frame that repeats without end. Each frame is a run of data symbols taken from the upstream coder, followed by a run of known probe symbols. A receiver can regenerate the probe symbols and use them to track the channel. The probe symbols come from an internal 9-bit shift-register generator, which restarts from a fixed seed at the start of every probe run. Upstream data moves through a valid/ready handshake that is open only in data slots. When the coder has nothing ready in a data slot, the block fills the slot with a zero symbol and raises an underflow flag. Each output symbol comes with its slot index and its segment type, so that a downstream checker can follow the frame.

Top module: `psk_probe_framer`

## Requirements
- R1: For each clock in which `sym_stb` is high, `out_valid` is high for exactly one clock on the following clock. `out_valid` is low in a clock that does not follow a strobe.
- R2: Strobes step through slots 0 to DATA_LEN+PROBE_LEN-1 and then wrap to 0. Slots 0 to DATA_LEN-1 are data slots and give `out_probe`=0. The remaining slots are probe slots and give `out_probe`=1 (defaults: 20 data slots, 16 probe slots).
- R3: `in_ready` is high only while `sym_stb` is high in a data slot. A transfer is `in_valid` and `in_ready` both high, and its `in_data` appears on `out_sym` with the next `out_valid`. In probe slots no transfer happens, and `in_data` has no effect on `out_sym`.
- R4: `out_idx` gives the slot number of the symbol currently on `out_sym`.
- R5: A probe slot at position j within its probe run (j from 0) outputs bits [2:0] of S_j. S_0 is the seed (default 9'h0B3). Each next state is S_{j+1} = {S_j[7:0], S_j[8]^S_j[4]}, which implements the polynomial x^9+x^5+1.
- R6: A data slot that has `in_valid` low outputs symbol 0, and `underflow` is high for that one output clock only.
- R7: Synchronous active-high `rst` clears `out_valid`, `out_sym`, `out_probe`, `out_idx` and `underflow`. The first strobe after reset is data slot 0.
- R8: The generator reloads its seed at the start of every probe run, so every probe run carries the same symbol sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | Symbol-period strobe, one clock wide |
| in_valid | input | 1 | Upstream data symbol valid |
| in_data | input | 3 | Upstream data symbol |
| in_ready | output | 1 | Framer takes a symbol this clock |
| out_valid | output | 1 | New symbol on the output |
| out_sym | output | 3 | Output phase symbol |
| out_probe | output | 1 | 1 = probe slot, 0 = data slot |
| out_idx | output | 6 | Slot index within the frame |
| underflow | output | 1 | Data slot filled with zero |

## Verification
The bench builds the block with its default parameters: 20 data slots, 16 probe slots, a 9-bit generator and seed 9'h0B3. With these values a 36-slot frame is short enough to run many times over. That makes the frame wrap, the repeated probe runs and the reload of the seed easy to observe. Random gaps between strobes and a random valid rate cover underflow slots and back-to-back strobes. Directed cases drive valid data into probe slots and apply a reset in the middle of a frame.

// File: rtl/psk_framer_pkg.sv
package psk_framer_pkg;
  typedef enum logic {
    SEG_DATA  = 1'b0,
    SEG_PROBE = 1'b1
  } seg_t;
endpackage

// File: rtl/framer_slot_ctr.sv
module framer_slot_ctr
  import psk_framer_pkg::*;
#(
  parameter int DATA_LEN  = 20,
  parameter int PROBE_LEN = 16,
  localparam int TOTAL = DATA_LEN + PROBE_LEN,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output seg_t             seg,
  output logic             last_data
);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (adv) begin
      if (idx == LAST_SLOT) idx <= '0;
      else                  idx <= idx + 1'b1;
    end
  end

  always_comb begin
    seg       = (idx > LAST_DATA) ? SEG_PROBE : SEG_DATA;
    last_data = (idx == LAST_DATA);
  end
endmodule

// File: rtl/framer_probe_gen.sv
module framer_probe_gen #(
  parameter int           LFSR_W = 9,
  parameter int           TAP_HI = 8,
  parameter int           TAP_LO = 4,
  parameter int           SYM_W  = 3,
  parameter logic [8:0]   SEED   = 9'h0B3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             step,
  output logic [SYM_W-1:0] sym
);
  logic [LFSR_W-1:0] state;
  logic              fb;

  assign fb  = state[TAP_HI] ^ state[TAP_LO];
  assign sym = state[SYM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      state <= SEED[LFSR_W-1:0];
    end else if (step) begin
      state <= {state[LFSR_W-2:0], fb};
    end
  end
endmodule

// File: rtl/psk_probe_framer.sv
module psk_probe_framer
  import psk_framer_pkg::*;
#(
  parameter int         SYM_W     = 3,
  parameter int         DATA_LEN  = 20,
  parameter int         PROBE_LEN = 16,
  parameter logic [8:0] SEED      = 9'h0B3,
  localparam int TOTAL = DATA_LEN + PROBE_LEN,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_stb,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_probe,
  output logic [IDX_W-1:0] out_idx,
  output logic             underflow
);
  logic [IDX_W-1:0] idx;
  seg_t             seg;
  logic             last_data;
  logic             is_data;
  logic [SYM_W-1:0] probe_sym;
  logic [SYM_W-1:0] data_sym;

  framer_slot_ctr #(
    .DATA_LEN (DATA_LEN),
    .PROBE_LEN(PROBE_LEN)
  ) slot_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (sym_stb),
    .idx      (idx),
    .seg      (seg),
    .last_data(last_data)
  );

  framer_probe_gen #(
    .LFSR_W(9),
    .TAP_HI(8),
    .TAP_LO(4),
    .SYM_W (SYM_W),
    .SEED  (SEED)
  ) probe_i (
    .clk   (clk),
    .rst   (rst),
    .reload(sym_stb & last_data),
    .step  (sym_stb & ~is_data),
    .sym   (probe_sym)
  );

  assign is_data  = (seg == SEG_DATA);
  assign in_ready = sym_stb & is_data;
  assign data_sym = in_valid ? in_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_probe <= 1'b0;
      out_idx   <= '0;
      underflow <= 1'b0;
    end else begin
      out_valid <= sym_stb;
      underflow <= sym_stb & is_data & ~in_valid;
      if (sym_stb) begin
        out_idx   <= idx;
        out_probe <= ~is_data;
        out_sym   <= is_data ? data_sym : probe_sym;
      end
    end
  end
endmodule

// File: rtl/psk_probe_framer_chk.sv
module psk_probe_framer_chk #(
  parameter int SYM_W    = 3,
  parameter int DATA_LEN = 20,
  parameter int TOTAL    = 36,
  parameter int IDX_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_stb,
  input logic             in_valid,
  input logic [SYM_W-1:0] in_data,
  input logic             in_ready,
  input logic             out_valid,
  input logic [SYM_W-1:0] out_sym,
  input logic             out_probe,
  input logic [IDX_W-1:0] out_idx,
  input logic             underflow
);
  p_ready_needs_stb_r3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> sym_stb);

  p_valid_after_stb_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && sym_stb) |=> out_valid);

  p_no_valid_without_stb_r1: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sym_stb) |=> !out_valid);

  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_idx) < TOTAL));

  p_seg_matches_idx_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_probe == (int'(out_idx) >= DATA_LEN)));

  p_underflow_zero_r6: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (out_valid && !out_probe && out_sym == '0));

  p_accept_passes_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_ready && in_valid) |=> (out_valid && !out_probe && out_sym == $past(in_data)));
endmodule

bind psk_probe_framer psk_probe_framer_chk #(
  .SYM_W   (SYM_W),
  .DATA_LEN(DATA_LEN),
  .TOTAL   (TOTAL),
  .IDX_W   (IDX_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .sym_stb  (sym_stb),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_sym  (out_sym),
  .out_probe(out_probe),
  .out_idx  (out_idx),
  .underflow(underflow)
);

// File: tb/psk_probe_framer_tb_top.sv
module psk_probe_framer_tb_top;
  localparam int         DATA_LEN  = 20;
  localparam int         PROBE_LEN = 16;
  localparam int         TOTAL     = DATA_LEN + PROBE_LEN;
  localparam logic [8:0] SEED      = 9'h0B3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_stb = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [2:0] out_sym;
  logic       out_probe;
  logic [5:0] out_idx;
  logic       underflow;

  int total = 0;
  int bad   = 0;
  int exp_idx = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psk_probe_framer dut_i (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_sym(out_sym), .out_probe(out_probe),
    .out_idx(out_idx), .underflow(underflow)
  );

  function automatic logic [2:0] probe_at(int j);
    logic [8:0] s = SEED;
    for (int k = 0; k < j; k++) s = {s[7:0], s[8] ^ s[4]};
    return s[2:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);
    chk(underflow == 1'b0, "R6 idle underflow", int'(underflow), 0);
  endtask

  task automatic do_slot(bit v, logic [2:0] d);
    bit         is_data = (exp_idx < DATA_LEN);
    logic [2:0] e_sym;
    sym_stb  = 1'b1;
    in_valid = v;
    in_data  = d;
    #1;
    chk(in_ready == is_data, "R3 in_ready", int'(in_ready), int'(is_data));
    if (is_data) e_sym = v ? d : 3'd0;
    else         e_sym = probe_at(exp_idx - DATA_LEN);
    @(negedge clk);
    sym_stb  = 1'b0;
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1 out_valid", int'(out_valid), 1);
    chk(int'(out_idx) == exp_idx, "R4 out_idx", int'(out_idx), exp_idx);
    chk(out_probe == !is_data, "R2 out_probe", int'(out_probe), int'(!is_data));
    if (is_data)
      chk(out_sym == e_sym, "R3 data symbol", int'(out_sym), int'(e_sym));
    else
      chk(out_sym == e_sym, "R5 R8 probe symbol", int'(out_sym), int'(e_sym));
    chk(underflow == (is_data && !v), "R6 underflow", int'(underflow), int'(is_data && !v));
    exp_idx = (exp_idx + 1) % TOTAL;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 0 && underflow == 0, "R7 reset flags", int'({out_valid, underflow}), 0);
    chk(out_sym == 0 && out_idx == 0 && out_probe == 0, "R7 reset data",
        int'({out_probe, out_idx, out_sym}), 0);
    rst = 1'b0;
    exp_idx = 0;
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd2024);
    do_reset();
    // directed first frame: full data
    for (int i = 0; i < TOTAL; i++) begin
      do_slot(1'b1, 3'(i));
      idle_check();
    end
    // R3: valid data during probe slots must be ignored; R6 underflow in data slot
    for (int i = 0; i < TOTAL; i++) begin
      do_slot((i % 7) != 3, 3'(7 - (i % 8)));
    end
    idle_check();
    // random frames with random gaps (R1 R2 R5 R8)
    for (int i = 0; i < 8 * TOTAL; i++) begin
      do_slot(($urandom % 4) != 0, 3'($urandom));
      r = $urandom % 3;
      for (int g = 0; g < int'(r); g++) idle_check();
    end
    // R7: mid-frame reset restarts at data slot 0
    for (int i = 0; i < 25; i++) do_slot(1'b1, 3'd5);
    do_reset();
    for (int i = 0; i < TOTAL + 4; i++) do_slot(1'b0, 3'd6);
    idle_check();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule